// File: doc/BRIEF.md
# Bit-per-line reset request domain

This block drives up to 32 active-low peripheral reset lines from one request register on a simple 32-bit register bus. Each implemented line owns one bit: writing 0 holds the line in reset and writing 1 lets it go. A second, read-only register reports whether each line's change has taken effect. Software changes single lines by reading the whole request word, editing one bit and writing the word back. It then polls the status word until the bit matches.

A status bit does not follow its request bit at once. Each line has a countdown of `SETTLE_CYCLES` clocks that starts on every change of its request bit, and the status bit takes the request value only when that countdown runs out. A per-instance valid mask selects which lines exist. Bits outside the mask are fixed at 0 in both registers and on the reset outputs. The bus has plain strobes with no back-pressure: a write takes effect on the clock edge where `wr_en` is high, and read data returns one cycle after `rd_en`, marked by `rd_valid`.

Top module: `linebit_reset_domain`

## Requirements
- R1: A read with `rd_en` high at one edge returns its data on `rdata` after that edge, with `rd_valid` high for exactly that one cycle. A read at byte offset 0x0 returns the request word as it stood before the edge.
- R2: `line_rst_n[i]` always equals request bit i. A value of 0 holds line i in reset and a value of 1 releases it.
- R3: A read at byte offset 0x4 returns the status word. Status bit i reads 0 while line i's settled state is "in reset" and 1 once its release has settled.
- R4: When a write changes request bit i at edge c, status bit i takes the new value at edge c+`SETTLE_CYCLES` and not earlier.
- R5: Lines whose `VALID_MASK` bit is 0 read 0 in the request word and the status word and drive 0 on `line_rst_n`, whatever is written.
- R6: A further change of request bit i before its countdown expires restarts the countdown from the latest change. If the bit returns to its current status value, the status bit never toggles.
- R7: Writes to offset 0x4 or to any other offset except 0x0 change nothing. Reads at offsets other than 0x0 and 0x4 return 0.
- R8: While `rst_n` is low and after it is released, every request bit and status bit is 0, so all lines are held in reset, and `rd_valid` is 0.
- R9: Lines settle independently. A write that leaves bit i unchanged does not disturb bit i's running countdown, even when it changes other bits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset within the domain |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid when `rd_valid` is high |
| rd_valid | output | 1 | High the cycle after a read strobe |
| line_rst_n | output | N_LINES | Active-low reset per line |

## Verification
Three events can land on the same edge: the countdown of one line expiring, a write that changes another line, and a read of the status word. The bench provokes this by writing a second line exactly `SETTLE_CYCLES` edges after a first. It also holds a status read open across the expiry edge, so that the pre-edge value and the post-edge value are sampled on consecutive cycles. A behavioural model built from per-line due times judges every cycle. It expects the expiring line to settle, the newly written line to start a fresh countdown, and the read to show the value from before the edge.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  // Byte offsets of the two registers inside the domain
  localparam int unsigned REQ_OFS  = 0;
  localparam int unsigned STAT_OFS = 4;
  localparam int unsigned BUS_W    = 32;
endpackage

// File: rtl/lsr_regs.sv
module lsr_regs
  import lsr_pkg::*;
#(
  parameter int unsigned N_LINES    = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter logic [N_LINES-1:0] VALID_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [N_LINES-1:0] stat_i,
  output logic [N_LINES-1:0] req_o,
  output logic [N_LINES-1:0] chg_o,
  output logic [BUS_W-1:0]   rdata,
  output logic               rd_valid
);
  logic               hit_req, hit_stat;
  logic [N_LINES-1:0] wr_val;
  logic [N_LINES-1:0] req_q;
  logic [BUS_W-1:0]   rd_word;

  assign hit_req  = (addr == ADDR_W'(REQ_OFS));
  assign hit_stat = (addr == ADDR_W'(STAT_OFS));
  assign wr_val   = wdata[N_LINES-1:0] & VALID_MASK;
  // One pulse per bit whose requested level actually changes this edge
  assign chg_o    = (wr_en && hit_req) ? (wr_val ^ req_q) : '0;
  assign req_o    = req_q;

  always_comb begin
    rd_word = '0;
    if (hit_req)       rd_word[N_LINES-1:0] = req_q;
    else if (hit_stat) rd_word[N_LINES-1:0] = stat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= '0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en && hit_req) req_q <= wr_val;
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/lsr_settle_cell.sv
module lsr_settle_cell #(
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic chg,
  output logic stat
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      stat <= 1'b0;
    end else begin
      if (chg)               cnt <= CW'(SETTLE_CYCLES);
      else if (cnt != '0)    cnt <= cnt - CW'(1);
      if (!chg && cnt == CW'(1)) stat <= req;
    end
  end
endmodule

// File: rtl/linebit_reset_domain.sv
module linebit_reset_domain
  import lsr_pkg::*;
#(
  parameter int unsigned N_LINES       = 32,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned SETTLE_CYCLES = 8,
  parameter logic [N_LINES-1:0] VALID_MASK = 32'h0FFF_FFF8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               rd_valid,
  output logic [N_LINES-1:0] line_rst_n
);
  logic [N_LINES-1:0] req_vec, chg_vec, stat_vec;

  lsr_regs #(
    .N_LINES(N_LINES), .ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .stat_i(stat_vec), .req_o(req_vec), .chg_o(chg_vec),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (VALID_MASK[i]) begin : g_impl
      lsr_settle_cell #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_cell (
        .clk(clk), .rst_n(rst_n), .req(req_vec[i]), .chg(chg_vec[i]),
        .stat(stat_vec[i])
      );
    end else begin : g_absent
      assign stat_vec[i] = 1'b0;
    end
  end

  assign line_rst_n = req_vec;
endmodule

// File: rtl/lsr_chk.sv
module lsr_chk #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter logic [N_LINES-1:0] VALID_MASK = '1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic               rd_valid,
  input logic [N_LINES-1:0] line_rst_n,
  input logic [N_LINES-1:0] stat_vec
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R1
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R1
  AST_UNUSED_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rst_n & ~VALID_MASK) == '0); // R5
  AST_UNUSED_STAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vec & ~VALID_MASK) == '0); // R5
  AST_REQ_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(0)) |=> $stable(line_rst_n)); // R7
  AST_STAT_MOVES_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_vec ^ $past(stat_vec)) & (stat_vec ^ line_rst_n)) == '0)); // R4
endmodule

bind linebit_reset_domain lsr_chk #(
  .N_LINES(N_LINES), .ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_valid(rd_valid), .line_rst_n(line_rst_n), .stat_vec(stat_vec)
);

// File: tb/sim_linebit_reset_domain.sv
module sim_linebit_reset_domain;
  localparam int CLK_PERIOD = 10;
  localparam int S = 8;
  localparam logic [31:0] MASK = 32'h0FFF_FFF8;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata, line_rst_n;
  logic rd_valid;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  linebit_reset_domain #(.N_LINES(32), .ADDR_W(4), .SETTLE_CYCLES(S),
                         .VALID_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .line_rst_n(line_rst_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: per-line due times
  logic [31:0] m_req, m_stat, m_rdata;
  bit m_rvalid;
  string m_rtag;
  bit pend[32];
  longint due[32];
  longint cyc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_stat = 0; m_rdata = 0; m_rvalid = 0; cyc = 0;
      for (int i = 0; i < 32; i++) begin pend[i] = 0; due[i] = 0; end
    end else begin
      logic [31:0] wv;
      bit hit;
      cyc++;
      if (rd_en) begin
        m_rdata = (addr == 0) ? m_req : (addr == 4) ? m_stat : 32'h0;
        m_rtag  = (addr == 0) ? "R1 req read" : (addr == 4) ? "R3 status read" : "R7 other read";
      end
      m_rvalid = rd_en;
      wv  = wdata & MASK;
      hit = wr_en && (addr == 0);
      for (int i = 0; i < 32; i++) begin
        if (hit && wv[i] != m_req[i]) begin
          pend[i] = 1; due[i] = cyc + S;
        end else if (pend[i] && due[i] == cyc) begin
          m_stat[i] = m_req[i]; pend[i] = 0;
        end
      end
      if (hit) m_req = wv;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 line outputs", line_rst_n, m_req);
    chk("R1 rd_valid", {31'b0, rd_valid}, {31'b0, m_rvalid});
    if (m_rvalid) chk(m_rtag, rdata, m_rdata);
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R8 lines in reset", line_rst_n, 32'h0);
    chk("R8 no rd_valid", {31'b0, rd_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk); rd_en = 1; addr = 0;
    @(negedge clk); chk("R8 req after reset", rdata, 32'h0); addr = 4;
    @(negedge clk); chk("R8 status after reset", rdata, 32'h0); rd_en = 0;

    // R5 / R4: release all, then watch status open-loop around the expiry edge
    wr(0, 32'hFFFF_FFFF);
    rd_en = 1; addr = 4;
    for (int k = 1; k <= S + 3; k++) begin
      @(negedge clk);
      chk($sformatf("R4 status k=%0d", k), rdata, (k >= S + 1) ? MASK : 32'h0);
    end
    addr = 0; @(negedge clk);
    chk("R5 masked request", rdata, MASK);
    rd_en = 0;
    chk("R5 masked lines", line_rst_n, MASK);

    // R7: writes to status and unused offsets ignored; unused read is 0
    wr(4, 32'h0); wr(8, 32'h0); wr(4'hC, 32'h0);
    chk("R7 lines untouched", line_rst_n, MASK);
    @(negedge clk); rd_en = 1; addr = 8;
    @(negedge clk); rd_en = 0; chk("R7 unused offset read", rdata, 32'h0);

    // R2/R3: hold line 5 in reset
    wr(0, MASK & ~32'h20); idle(S + 2);
    @(negedge clk); rd_en = 1; addr = 4;
    @(negedge clk); rd_en = 0; chk("R3 line5 status", rdata, MASK & ~32'h20);

    // R6: line 7 dips and returns before expiry; status stays 1
    wr(0, MASK & ~32'hA0); idle(2); wr(0, MASK & ~32'h20);
    rd_en = 1; addr = 4;
    for (int k = 0; k < 2 * S; k++) begin
      @(negedge clk); chk("R6 line7 never toggles", rdata & 32'h80, 32'h80);
    end
    rd_en = 0;

    // R6: restart from latest change on line 10
    wr(0, MASK & ~32'h420); idle(1); wr(0, MASK & ~32'h20); idle(1);
    wr(0, MASK & ~32'h420); idle(2 * S);

    // R9 + same-edge expiry and write: line 11 then line 12 exactly S edges later
    wr(0, MASK & ~32'hC20 | 32'h400);
    idle(S - 2);
    @(negedge clk); wr_en = 1; addr = 0; wdata = MASK & ~32'h1C20;
    rd_en = 1;
    @(negedge clk); wr_en = 0; addr = 4;
    idle(2 * S); rd_en = 0;

    // R9: mixed traffic
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      @(negedge clk);
      wr_en = (lfsr[3:0] < 4'd3);
      rd_en = lfsr[5];
      addr  = lfsr[7] ? 4'h4 : (lfsr[8] ? 4'h0 : {lfsr[10:9], 2'b00});
      if (wr_en) addr = lfsr[11] ? 4'h0 : 4'h4;
      wdata = lfsr ^ {lfsr[15:0], lfsr[31:16]};
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    idle(2 * S);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule